// File: doc/BRIEF.md
# I2C Bus Master with Programmable Clock Timer

This block drives a two-wire I2C bus as its only master. Software reaches it through a small word-addressed register bus. To start a transfer it loads a 7-bit target address and a direction flag, puts a byte in the data register, and writes a three-bit command made of RUN, START and STOP. From that one command the block produces the bus sequence: a start or repeated start, the address byte, one data byte and, when asked, a stop. It samples every acknowledge. When STOP is left out, the block keeps the bus. Later commands can then continue with more data bytes, issue a repeated start, or release the bus with a stop.

SCL timing comes from a timer-period value TPR. Every bit slot has ten time units: six with SCL low and four with SCL high. One unit lasts 2*(1+TPR) system clocks. For example, a 20 MHz clock with TPR = 9 gives 100 kbit/s. Completion of each command raises a raw interrupt flag. That flag can be masked onto an interrupt line and is cleared by writing 1 to the clear register.

Register offsets: address 0x00 (bits 7:1 target, bit 0 direction, 1 = read), command/status 0x04, data 0x08, timer period 0x0C (reset value 1), interrupt mask 0x10, raw interrupt 0x14, masked interrupt 0x18, interrupt clear 0x1C, configuration 0x20 (bit 5 = master enable). All registers other than the timer period reset to zero.

Command write bits: bit 0 RUN, bit 1 START, bit 2 STOP.

Status read bits: bit 0 busy, bit 1 error, bit 2 address NACK, bit 3 data NACK, bit 6 bus held.

Top module: `i2c_host_ctrl`

## Requirements
- R1: After reset the timer period register reads 1, every other register reads 0, SCL and SDA are released high and irq_o is low; while idle both lines stay high.
- R2: During a byte, SCL is low for 6*2*(1+TPR) clocks and high for 4*2*(1+TPR) clocks of each bit slot.
- R3: The command 0x07 (written to offset 0x04) while idle produces START, the byte {target, direction}, the data byte and STOP, each byte followed by an ACK bit. Status bit 0 reads 1 while the transfer runs and the status reads 0x00 once it ends.
- R4: If the address byte is not acknowledged, status bits 1 and 2 are set, no data byte is sent, and a stop follows when STOP was requested, giving status 0x06.
- R5: A NACK on a written data byte sets status bits 1 and 3, giving status 0x0A after the stop.
- R6: With direction 1 the block reads one byte into the data register. It NACKs that byte when STOP was requested and ACKs it otherwise.
- R7: A command without STOP leaves the bus held: status reads 0x40 and SCL stays low. RUN alone (0x01) then transfers one more data byte without an address, and STOP alone (0x04) releases the bus with a stop.
- R8: START with RUN while the bus is held produces a repeated start, with no stop before it.
- R9: Each completed command sets raw interrupt bit 0. The masked register and irq_o equal raw AND mask bit 0. Writing 1 to the clear register clears the raw bit.
- R10: While configuration bit 5 is 0, command writes have no effect: busy stays 0, the lines stay idle and no interrupt is raised.
- R11: RUN without START while the bus is idle is ignored. During byte slots SDA changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | Write enable for the access |
| bus_addr_i | input | BUS_AW | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| scl_o | output | 1 | SCL level driven (0 pulls low, 1 releases) |
| sda_o | output | 1 | SDA level driven (0 pulls low, 1 releases) |
| sda_i | input | 1 | Resolved SDA line level |
| irq_o | output | 1 | Masked completion interrupt |

## Verification
Some rules hold on every cycle, and assertions check them continuously. While the engine is idle, both lines are released. While the bus is held, SCL stays low. During byte slots, SDA does not move while SCL is high. Timer ticks are never adjacent. Busy can rise only when the master is enabled, and the raw interrupt rises only after a completion.

Other behaviour shows only in the bench's scenarios. These cover the order of start, address, data, acknowledge and stop events seen by a modelled target, and the measured SCL low and high times. They also cover the NACK paths and the status codes they leave, the data read back into the data register, repeated start and continuation from a held bus, and commands that are ignored while disabled or idle.

// File: rtl/i2c_host_pkg.sv
package i2c_host_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_START, ST_BYTE, ST_STOP, ST_HOLD} eng_st_e;

  localparam int CMD_RUN   = 0;
  localparam int CMD_START = 1;
  localparam int CMD_STOP  = 2;

  localparam int SB_BUSY  = 0;
  localparam int SB_ERR   = 1;
  localparam int SB_ANACK = 2;
  localparam int SB_DNACK = 3;
  localparam int SB_HELD  = 6;

  localparam int CFG_EN_BIT = 5;

  localparam logic [7:0] OFF_TGT  = 8'h00;
  localparam logic [7:0] OFF_CS   = 8'h04;
  localparam logic [7:0] OFF_DATA = 8'h08;
  localparam logic [7:0] OFF_TPR  = 8'h0C;
  localparam logic [7:0] OFF_MASK = 8'h10;
  localparam logic [7:0] OFF_RIS  = 8'h14;
  localparam logic [7:0] OFF_MIS  = 8'h18;
  localparam logic [7:0] OFF_ICR  = 8'h1C;
  localparam logic [7:0] OFF_CFG  = 8'h20;

  localparam int UNITS_LOW  = 6;
  localparam int UNITS_HIGH = 4;
  localparam int UNITS_SLOT = UNITS_LOW + UNITS_HIGH;
  localparam int UNIT_W     = $clog2(UNITS_SLOT);
  // unit indices inside a slot
  localparam int UNIT_SDA_SET  = 2;  // data update, SCL low
  localparam int UNIT_SDA_EDGE = 7;  // start/stop edge, SCL high
  localparam int UNIT_SAMPLE   = 8;  // sample, SCL high
endpackage

// File: rtl/i2c_host_tick.sv
module i2c_host_tick #(
  parameter int TPR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [TPR_W-1:0] tpr_i,
  output logic             tick_o
);
  localparam int CW = TPR_W + 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;

  assign limit  = {tpr_i, 1'b1};  // 2*(1+TPR) clocks per unit
  assign tick_o = en_i && (cnt_q == limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!en_i || tick_o)  cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

  assert_tick_spacing_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/i2c_host_engine.sv
module i2c_host_engine
  import i2c_host_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       go_i,
  input  logic [2:0] cmd_i,
  input  logic       rx_i,
  input  logic [6:0] tgt_i,
  input  logic [7:0] txd_i,
  input  logic       tick_i,
  input  logic       sda_i,
  output logic       scl_o,
  output logic       sda_o,
  output logic       busy_o,
  output logic       owned_o,
  output logic       done_o,
  output logic       addr_nack_o,
  output logic       data_nack_o,
  output logic [7:0] rxd_o,
  output logic       rxd_we_o
);
  localparam logic [UNIT_W-1:0] LAST_UNIT = UNIT_W'(UNITS_SLOT - 1);

  eng_st_e           st_q;
  logic [UNIT_W-1:0] unit_q;
  logic [3:0]        bitn_q;
  logic [7:0]        sh_q;
  logic              is_addr_q, stop_q, rx_q, hold_q, samp_q;
  logic              sda_q, scl_q, anack_q, dnack_q, done_q, rxd_we_q;
  logic              accept, scl_d, bit_out, own_bit;
  eng_st_e           end_st;

  assign busy_o      = (st_q != ST_IDLE) && (st_q != ST_HOLD);
  assign owned_o     = (st_q != ST_IDLE);
  assign scl_o       = scl_q;
  assign sda_o       = sda_q;
  assign done_o      = done_q;
  assign addr_nack_o = anack_q;
  assign data_nack_o = dnack_q;
  assign rxd_o       = sh_q;
  assign rxd_we_o    = rxd_we_q;

  always_comb begin
    accept = 1'b0;
    if (go_i) begin
      case (st_q)
        ST_IDLE: accept = cmd_i[CMD_RUN] && cmd_i[CMD_START];
        ST_HOLD: accept = cmd_i[CMD_RUN] || cmd_i[CMD_STOP];
        default: accept = 1'b0;
      endcase
    end
  end

  // master drives the byte unless it is receiving data
  assign own_bit = is_addr_q || !rx_q;
  always_comb begin
    if (bitn_q == 4'd8) bit_out = own_bit ? 1'b1 : stop_q;  // NACK last read byte
    else                bit_out = own_bit ? sh_q[7] : 1'b1;
  end

  assign end_st = stop_q ? ST_STOP : ST_HOLD;

  always_comb begin
    case (st_q)
      ST_IDLE:  scl_d = 1'b1;
      ST_HOLD:  scl_d = 1'b0;
      ST_START: scl_d = (unit_q < UNIT_W'(UNITS_LOW)) ? !hold_q : 1'b1;
      default:  scl_d = (unit_q >= UNIT_W'(UNITS_LOW));
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;  unit_q <= '0;  bitn_q <= '0;  sh_q <= '0;
      is_addr_q <= 1'b0; stop_q <= 1'b0; rx_q <= 1'b0; hold_q <= 1'b0;
      samp_q <= 1'b1; sda_q <= 1'b1; scl_q <= 1'b1;
      anack_q <= 1'b0; dnack_q <= 1'b0; done_q <= 1'b0; rxd_we_q <= 1'b0;
    end else begin
      done_q   <= 1'b0;
      rxd_we_q <= 1'b0;
      scl_q    <= scl_d;
      if (accept) begin
        anack_q <= 1'b0;
        dnack_q <= 1'b0;
        stop_q  <= cmd_i[CMD_STOP];
        unit_q  <= '0;
        bitn_q  <= '0;
        if (cmd_i[CMD_RUN] && cmd_i[CMD_START]) begin
          st_q   <= ST_START;
          hold_q <= (st_q == ST_HOLD);
          rx_q   <= rx_i;
        end else if (cmd_i[CMD_RUN]) begin
          st_q      <= ST_BYTE;
          is_addr_q <= 1'b0;
          sh_q      <= txd_i;
        end else begin
          st_q <= ST_STOP;
        end
      end else if (busy_o && tick_i) begin
        if (unit_q == UNIT_W'(UNIT_SAMPLE)) samp_q <= sda_i;
        if (unit_q == UNIT_W'(UNIT_SDA_SET)) begin
          case (st_q)
            ST_START: sda_q <= 1'b1;
            ST_STOP:  sda_q <= 1'b0;
            default:  sda_q <= bit_out;
          endcase
        end
        if (unit_q == UNIT_W'(UNIT_SDA_EDGE) && st_q != ST_BYTE)
          sda_q <= (st_q == ST_STOP);
        if (unit_q == LAST_UNIT) begin
          unit_q <= '0;
          case (st_q)
            ST_START: begin
              st_q      <= ST_BYTE;
              is_addr_q <= 1'b1;
              sh_q      <= {tgt_i, rx_q};
              bitn_q    <= '0;
            end
            ST_BYTE: begin
              if (bitn_q != 4'd8) begin
                sh_q   <= {sh_q[6:0], samp_q};
                bitn_q <= bitn_q + 4'd1;
              end else begin
                bitn_q <= '0;
                if (is_addr_q && samp_q) begin
                  anack_q <= 1'b1;
                  st_q    <= end_st;
                  done_q  <= !stop_q;
                end else if (is_addr_q) begin
                  is_addr_q <= 1'b0;
                  sh_q      <= txd_i;
                end else begin
                  if (rx_q) rxd_we_q <= 1'b1;
                  else if (samp_q) dnack_q <= 1'b1;
                  st_q   <= end_st;
                  done_q <= !stop_q;
                end
              end
            end
            ST_STOP: begin
              st_q   <= ST_IDLE;
              done_q <= 1'b1;
            end
            default: st_q <= st_q;
          endcase
        end else begin
          unit_q <= unit_q + 1'b1;
        end
      end
    end
  end

  assert_idle_release_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && $past(st_q) == ST_IDLE) |-> (scl_q && sda_q));
  assert_hold_scl_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HOLD && $past(st_q) == ST_HOLD) |-> !scl_q);
  assert_sda_low_phase_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_BYTE && $past(st_q) == ST_BYTE && scl_q && $past(scl_q)) |-> $stable(sda_q));
  assert_go_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> busy_o);
endmodule

// File: rtl/i2c_host_regs.sv
module i2c_host_regs
  import i2c_host_pkg::*;
#(
  parameter int BUS_AW = 6,
  parameter int DATA_W = 32,
  parameter int TPR_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [BUS_AW-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [7:0]        stat_i,
  input  logic              done_i,
  input  logic [7:0]        rxd_i,
  input  logic              rxd_we_i,
  output logic [6:0]        tgt_o,
  output logic              rx_o,
  output logic [7:0]        txd_o,
  output logic [TPR_W-1:0]  tpr_o,
  output logic              go_o,
  output logic [2:0]        cmd_o,
  output logic              en_o,
  output logic              irq_o
);
  logic [6:0]       tgt_q;
  logic             rx_q, mask_q, ris_q, en_q;
  logic [7:0]       data_q;
  logic [TPR_W-1:0] tpr_q;
  logic             wr;

  assign wr    = req_i && we_i;
  assign go_o  = wr && (addr_i == BUS_AW'(OFF_CS)) && en_q;
  assign cmd_o = wdata_i[2:0];
  assign tgt_o = tgt_q;
  assign rx_o  = rx_q;
  assign txd_o = data_q;
  assign tpr_o = tpr_q;
  assign en_o  = en_q;
  assign irq_o = ris_q && mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_q <= '0; rx_q <= 1'b0; data_q <= '0; tpr_q <= TPR_W'(1);
      mask_q <= 1'b0; ris_q <= 1'b0; en_q <= 1'b0;
    end else begin
      if (wr) begin
        if (addr_i == BUS_AW'(OFF_TGT))  {tgt_q, rx_q} <= wdata_i[7:0];
        if (addr_i == BUS_AW'(OFF_DATA)) data_q <= wdata_i[7:0];
        if (addr_i == BUS_AW'(OFF_TPR))  tpr_q <= wdata_i[TPR_W-1:0];
        if (addr_i == BUS_AW'(OFF_MASK)) mask_q <= wdata_i[0];
        if (addr_i == BUS_AW'(OFF_CFG))  en_q <= wdata_i[CFG_EN_BIT];
      end
      if (rxd_we_i) data_q <= rxd_i;
      if (done_i) ris_q <= 1'b1;
      else if (wr && addr_i == BUS_AW'(OFF_ICR) && wdata_i[0]) ris_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      BUS_AW'(OFF_TGT):  rdata_o = DATA_W'({tgt_q, rx_q});
      BUS_AW'(OFF_CS):   rdata_o = DATA_W'(stat_i);
      BUS_AW'(OFF_DATA): rdata_o = DATA_W'(data_q);
      BUS_AW'(OFF_TPR):  rdata_o = DATA_W'(tpr_q);
      BUS_AW'(OFF_MASK): rdata_o = DATA_W'(mask_q);
      BUS_AW'(OFF_RIS):  rdata_o = DATA_W'(ris_q);
      BUS_AW'(OFF_MIS):  rdata_o = DATA_W'(ris_q && mask_q);
      BUS_AW'(OFF_CFG):  rdata_o = DATA_W'({en_q, 5'b0});
      default:           rdata_o = '0;
    endcase
  end

  assert_ris_source_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ris_q) |-> $past(done_i));
endmodule

// File: rtl/i2c_host_ctrl.sv
module i2c_host_ctrl
  import i2c_host_pkg::*;
#(
  parameter int BUS_AW = 6,
  parameter int TPR_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [BUS_AW-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              scl_o,
  output logic              sda_o,
  input  logic              sda_i,
  output logic              irq_o
);
  logic [6:0]       tgt;
  logic             rx, go, en, tick, busy, owned, done, anack, dnack, rxd_we;
  logic [7:0]       txd, rxd, stat;
  logic [2:0]       cmd;
  logic [TPR_W-1:0] tpr;

  always_comb begin
    stat           = '0;
    stat[SB_BUSY]  = busy;
    stat[SB_ERR]   = anack || dnack;
    stat[SB_ANACK] = anack;
    stat[SB_DNACK] = dnack;
    stat[SB_HELD]  = owned;
  end

  i2c_host_regs #(.BUS_AW(BUS_AW), .DATA_W(32), .TPR_W(TPR_W)) u_regs (
    .clk_i, .rst_ni,
    .req_i(bus_req_i), .we_i(bus_we_i), .addr_i(bus_addr_i),
    .wdata_i(bus_wdata_i), .rdata_o(bus_rdata_o),
    .stat_i(stat), .done_i(done), .rxd_i(rxd), .rxd_we_i(rxd_we),
    .tgt_o(tgt), .rx_o(rx), .txd_o(txd), .tpr_o(tpr),
    .go_o(go), .cmd_o(cmd), .en_o(en), .irq_o
  );

  i2c_host_tick #(.TPR_W(TPR_W)) u_tick (
    .clk_i, .rst_ni, .en_i(busy), .tpr_i(tpr), .tick_o(tick)
  );

  i2c_host_engine u_eng (
    .clk_i, .rst_ni, .go_i(go), .cmd_i(cmd), .rx_i(rx), .tgt_i(tgt),
    .txd_i(txd), .tick_i(tick), .sda_i,
    .scl_o, .sda_o, .busy_o(busy), .owned_o(owned), .done_o(done),
    .addr_nack_o(anack), .data_nack_o(dnack), .rxd_o(rxd), .rxd_we_o(rxd_we)
  );

  assert_enable_gate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(en));
endmodule

// File: tb/i2c_host_ctrl_test.sv
module i2c_host_ctrl_test;
  localparam logic [5:0] A_TGT = 6'h00, A_CS = 6'h04, A_DATA = 6'h08, A_TPR = 6'h0C,
                         A_MASK = 6'h10, A_RIS = 6'h14, A_MIS = 6'h18, A_ICR = 6'h1C,
                         A_CFG = 6'h20;
  localparam logic [6:0] TGT_ADDR = 7'h3B;
  localparam logic [1:0] EV_START = 2'd1, EV_BYTE = 2'd2, EV_STOP = 2'd3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata;
  logic        scl_o, sda_o, irq;
  logic        tgt_sda = 1'b1;
  wire         sda_line = sda_o & tgt_sda;

  always #2 clk = ~clk;

  i2c_host_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(bus_req), .bus_we_i(bus_we),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(rdata),
    .scl_o(scl_o), .sda_o(sda_o), .sda_i(sda_line), .irq_o(irq)
  );

  int checks = 0, fails = 0;
  logic [10:0] exp_q[$];
  string       exp_req_q[$];
  bit          mon_on = 1'b0;

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic expect_ev(input string req, input logic [1:0] t, input logic ack,
                           input logic [7:0] b);
    exp_q.push_back({t, ack, b});
    exp_req_q.push_back(req);
  endtask

  task automatic observe(input logic [10:0] it);
    logic [10:0] e;
    string r;
    if (!mon_on) return;
    checks++;
    if (exp_q.size() == 0) begin
      fails++;
      $display("FAIL R3 unexpected bus event act=%h exp=none", it);
    end else begin
      e = exp_q.pop_front();
      r = exp_req_q.pop_front();
      if (e !== it) begin
        fails++;
        $display("FAIL %s bus event act=%h exp=%h", r, it, e);
      end
    end
  endtask

  // target model on the bus, also acting as the scoreboard monitor
  int          bitc = 0;
  logic [7:0]  tsh = '0, tgt_out = '0, tgt_next = 8'h96;
  bit          addr_ph = 0, tgt_rd = 0, matched = 0, first = 0, mst_ack = 0;
  bit          tgt_nack_data = 0;

  always @(negedge sda_line) if (mon_on && scl_o === 1'b1) begin
    observe({EV_START, 1'b0, 8'h00});
    bitc = 0; addr_ph = 1; first = 1; tgt_sda = 1'b1;
  end
  always @(posedge sda_line) if (mon_on && scl_o === 1'b1) begin
    observe({EV_STOP, 1'b0, 8'h00});
    addr_ph = 0; tgt_rd = 0;
  end
  always @(posedge scl_o) if (mon_on) begin
    if (bitc < 8) tsh = {tsh[6:0], sda_line};
    else begin
      mst_ack = !sda_line;
      observe({EV_BYTE, !sda_line, tsh});
    end
  end
  always @(negedge scl_o) if (mon_on) begin
    if (first) first = 0;
    else begin
      tgt_sda = 1'b1;
      if (bitc == 8) begin
        bitc = 0;
        if (addr_ph) begin addr_ph = 0; tgt_rd = matched && tsh[0]; end
        else if (tgt_rd && !mst_ack) tgt_rd = 0;
        if (tgt_rd) begin
          tgt_out = tgt_next; tgt_next = tgt_next + 8'h22; tgt_sda = tgt_out[7];
        end
      end else begin
        bitc++;
        if (bitc == 8) begin
          if (addr_ph) begin matched = (tsh[7:1] == TGT_ADDR); tgt_sda = !matched; end
          else if (!tgt_rd) tgt_sda = tgt_nack_data;
        end else if (tgt_rd) tgt_sda = tgt_out[7-bitc];
      end
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1 d = rdata;
  endtask

  task automatic wait_done();
    logic [31:0] s;
    for (int i = 0; i < 20000; i++) begin
      rd(A_CS, s);
      if (!s[0]) return;
    end
    chk("R3", "busy never cleared", 32'h1, 32'h0);
  endtask

  task automatic run_watchdog();
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    logic [31:0] d;
    int n;
    fork run_watchdog(); join_none

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    mon_on = 1'b1;

    // R1 reset state
    rd(A_TPR, d);  chk("R1", "tpr reset", d, 32'h1);
    rd(A_TGT, d);  chk("R1", "addr reset", d, 32'h0);
    rd(A_CS, d);   chk("R1", "status reset", d, 32'h0);
    rd(A_DATA, d); chk("R1", "data reset", d, 32'h0);
    rd(A_MASK, d); chk("R1", "mask reset", d, 32'h0);
    rd(A_RIS, d);  chk("R1", "ris reset", d, 32'h0);
    rd(A_CFG, d);  chk("R1", "cfg reset", d, 32'h0);
    chk("R1", "lines idle", {30'b0, scl_o, sda_o}, 32'h3);
    chk("R1", "irq reset", {31'b0, irq}, 32'h0);

    // R10 disabled master ignores command
    wr(A_TGT, 32'h76); wr(A_DATA, 32'h5C); wr(A_CS, 32'h07);
    n = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk); if (!scl_o || !sda_o) n++;
    end
    chk("R10", "lines moved while disabled", n, 0);
    rd(A_CS, d);  chk("R10", "status while disabled", d, 32'h0);
    rd(A_RIS, d); chk("R10", "ris while disabled", d, 32'h0);

    // R3 single byte send
    wr(A_CFG, 32'h20);
    rd(A_CFG, d); chk("R10", "cfg enable readback", d, 32'h20);
    expect_ev("R3", EV_START, 0, 0); expect_ev("R3", EV_BYTE, 1, 8'h76);
    expect_ev("R3", EV_BYTE, 1, 8'h5C); expect_ev("R3", EV_STOP, 0, 0);
    wr(A_CS, 32'h07);
    rd(A_CS, d); chk("R3", "status while running", d, 32'h41);
    wait_done();
    rd(A_CS, d); chk("R3", "status after send", d, 32'h0);

    // R9 interrupts
    rd(A_RIS, d); chk("R9", "raw set after done", d, 32'h1);
    rd(A_MIS, d); chk("R9", "masked with mask 0", d, 32'h0);
    chk("R9", "irq with mask 0", {31'b0, irq}, 32'h0);
    wr(A_MASK, 32'h1);
    rd(A_MIS, d); chk("R9", "masked with mask 1", d, 32'h1);
    chk("R9", "irq with mask 1", {31'b0, irq}, 32'h1);
    wr(A_ICR, 32'h1);
    rd(A_RIS, d); chk("R9", "raw after clear", d, 32'h0);
    chk("R9", "irq after clear", {31'b0, irq}, 32'h0);
    wr(A_MASK, 32'h0);

    // R11 RUN alone while idle is ignored
    wr(A_CS, 32'h01);
    n = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk); if (!scl_o) n++;
    end
    chk("R11", "scl moved on idle RUN", n, 0);
    rd(A_CS, d);  chk("R11", "status on idle RUN", d, 32'h0);
    rd(A_RIS, d); chk("R11", "ris on idle RUN", d, 32'h0);

    // R2 SCL phase timing with TPR=2 (unit 6 clocks)
    wr(A_TPR, 32'h2);
    expect_ev("R2", EV_START, 0, 0); expect_ev("R2", EV_BYTE, 1, 8'h76);
    expect_ev("R2", EV_BYTE, 1, 8'h5C); expect_ev("R2", EV_STOP, 0, 0);
    wr(A_CS, 32'h07);
    @(negedge scl_o);
    n = 0;
    while (scl_o == 1'b0) begin @(posedge clk); #1; n++; end
    chk("R2", "scl low clocks", n, 36);
    n = 0;
    while (scl_o == 1'b1) begin @(posedge clk); #1; n++; end
    chk("R2", "scl high clocks", n, 24);
    wait_done();
    wr(A_TPR, 32'h1);

    // R4 address NACK
    wr(A_TGT, 32'h50);
    expect_ev("R4", EV_START, 0, 0); expect_ev("R4", EV_BYTE, 0, 8'h50);
    expect_ev("R4", EV_STOP, 0, 0);
    wr(A_CS, 32'h07);
    wait_done();
    rd(A_CS, d); chk("R4", "status after addr nack", d, 32'h06);

    // R5 data NACK
    tgt_nack_data = 1;
    wr(A_TGT, 32'h76); wr(A_DATA, 32'h33);
    expect_ev("R5", EV_START, 0, 0); expect_ev("R5", EV_BYTE, 1, 8'h76);
    expect_ev("R5", EV_BYTE, 0, 8'h33); expect_ev("R5", EV_STOP, 0, 0);
    wr(A_CS, 32'h07);
    wait_done();
    rd(A_CS, d); chk("R5", "status after data nack", d, 32'h0A);
    tgt_nack_data = 0;

    // R7 hold, then RUN alone continues
    wr(A_DATA, 32'h11);
    expect_ev("R7", EV_START, 0, 0); expect_ev("R7", EV_BYTE, 1, 8'h76);
    expect_ev("R7", EV_BYTE, 1, 8'h11);
    wr(A_CS, 32'h03);
    wait_done();
    rd(A_CS, d); chk("R7", "status when held", d, 32'h40);
    repeat (20) @(negedge clk);
    chk("R7", "scl low when held", {31'b0, scl_o}, 32'h0);
    wr(A_DATA, 32'h22);
    expect_ev("R7", EV_BYTE, 1, 8'h22);
    wr(A_CS, 32'h01);
    wait_done();
    rd(A_CS, d); chk("R7", "status after continue", d, 32'h40);

    // R8 repeated start from held bus
    wr(A_DATA, 32'h44);
    expect_ev("R8", EV_START, 0, 0); expect_ev("R8", EV_BYTE, 1, 8'h76);
    expect_ev("R8", EV_BYTE, 1, 8'h44); expect_ev("R8", EV_STOP, 0, 0);
    wr(A_CS, 32'h07);
    wait_done();
    rd(A_CS, d); chk("R8", "status after repeated start", d, 32'h0);

    // R6 single byte read, NACKed because STOP set
    wr(A_TGT, 32'h77);
    expect_ev("R6", EV_START, 0, 0); expect_ev("R6", EV_BYTE, 1, 8'h77);
    expect_ev("R6", EV_BYTE, 0, 8'h96); expect_ev("R6", EV_STOP, 0, 0);
    wr(A_CS, 32'h07);
    wait_done();
    rd(A_DATA, d); chk("R6", "read byte", d, 32'h96);
    rd(A_CS, d);   chk("R6", "status after read", d, 32'h0);

    // R6 read with ACK and hold, then RUN+STOP reads last byte
    expect_ev("R6", EV_START, 0, 0); expect_ev("R6", EV_BYTE, 1, 8'h77);
    expect_ev("R6", EV_BYTE, 1, 8'hB8);
    wr(A_CS, 32'h03);
    wait_done();
    rd(A_DATA, d); chk("R6", "acked read byte", d, 32'hB8);
    rd(A_CS, d);   chk("R7", "status held after read", d, 32'h40);
    expect_ev("R6", EV_BYTE, 0, 8'hDA); expect_ev("R6", EV_STOP, 0, 0);
    wr(A_CS, 32'h05);
    wait_done();
    rd(A_DATA, d); chk("R6", "last read byte", d, 32'hDA);

    // R7 STOP alone releases a held bus
    wr(A_TGT, 32'h76); wr(A_DATA, 32'h55);
    expect_ev("R7", EV_START, 0, 0); expect_ev("R7", EV_BYTE, 1, 8'h76);
    expect_ev("R7", EV_BYTE, 1, 8'h55);
    wr(A_CS, 32'h03);
    wait_done();
    expect_ev("R7", EV_STOP, 0, 0);
    wr(A_CS, 32'h04);
    wait_done();
    rd(A_CS, d); chk("R7", "status after stop only", d, 32'h0);
    repeat (20) @(negedge clk);
    chk("R1", "lines idle at end", {30'b0, scl_o, sda_o}, 32'h3);
    chk("R3", "all expected events seen", exp_q.size(), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule